// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels owns the shared memory bus. A channel raises its request line when it has a block burst ready to move. The arbiter hands the bus to a single channel through a one-hot grant vector. That channel keeps the bus until it pulses its block-done line, so a multi-word block always goes out as one piece. A new winner is chosen only when the bus is idle or at the end of a block, and the choice shows on the grant vector one clock later.

A 32-bit global control word sets the selection policy. Bit 31 chooses fixed priority or rotating (round-robin) priority, and the policy can change while the block runs. Bits 19..16 hold a 4-bit cycle-selection value. The arbiter does not use this value itself; it only stores it and drives it out for neighbouring logic. The memory bus, address generation and channel sequencing all live outside this block.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, grant is all zeros and cfg_rdata and cycle_sel are zero.
- R2: A write with cfg_we stores bit 31 (policy) and bits 19..16 (cycle selection) of cfg_wdata. cfg_rdata shows those bits on the next cycle, and every other bit of cfg_rdata reads as zero.
- R3: cycle_sel always equals bits 19..16 of the stored control word.
- R4: grant has at most one bit set at any time.
- R5: An arbitration point is a cycle in which grant is zero, or in which the grant holder has its blk_done bit high. At such a point, if any request is high, the next cycle grants exactly one requesting channel.
- R6: Between arbitration points the grant does not change. Other channels' requests and the holder dropping its own request make no difference.
- R7: A blk_done pulse from a channel that does not hold the grant is ignored, and the grant stays as it is.
- R8: An arbitration point with no request high leaves grant at zero on the next cycle.
- R9: With policy bit 31 = 0 (fixed), the lowest-numbered requesting channel wins: channel 0 is highest and channel 3 lowest.
- R10: With policy bit 31 = 1 (round robin), the search starts at the channel after the last one granted and wraps from 3 to 0. After reset the last granted channel counts as channel 3.
- R11: A policy written during a burst is used first at the next arbitration point after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the global control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Stored control word (unused bits read as zero) |
| cycle_sel | output | 4 | Stored cycle-selection value |
| req | input | 4 | Per-channel burst request |
| blk_done | input | 4 | Per-channel end-of-block pulse |
| grant | output | 4 | One-hot bus grant |

## Verification
Every result comes from a single register stage. A grant change shows one rising edge after the arbitration-point cycle, and a control write shows on cfg_rdata and cycle_sel one rising edge after the strobe. The bench changes inputs on the falling edge and checks on the following falling edge, so exactly one rising edge falls between stimulus and check. Hold and ignore cases are checked over several such steps to confirm that nothing moves. The policy-switch scenarios pick request patterns where fixed and rotating priority give different winners. Only the active policy can then produce the expected grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CFG_W    = 32;
  localparam int POL_BIT  = 31;
  localparam int CSEL_LSB = 16;
  localparam int CSEL_W   = 4;

  typedef enum logic {
    POL_FIXED = 1'b0,
    POL_ROUND = 1'b1
  } arb_policy_e;
endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg
  import dma_arb_pkg::*;
#(
  parameter int DW    = CFG_W,
  parameter int PBIT  = POL_BIT,
  parameter int SLSB  = CSEL_LSB,
  parameter int SW    = CSEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output arb_policy_e   policy,
  output logic [SW-1:0] csel,
  output logic [DW-1:0] rdata
);
  arb_policy_e   pol_q;
  logic [SW-1:0] csel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q  <= POL_FIXED;
      csel_q <= '0;
    end else if (we) begin
      pol_q  <= arb_policy_e'(wdata[PBIT]);
      csel_q <= wdata[SLSB +: SW];
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[PBIT]        = pol_q;
    rdata[SLSB +: SW]  = csel_q;
  end

  assign policy = pol_q;
  assign csel   = csel_q;
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [IW-1:0]  last_idx,
  output logic [NCH-1:0] pick_vec,
  output logic [IW-1:0]  pick_idx,
  output logic           pick_any
);
  // Scan from lowest priority to highest so the last hit wins.
  always_comb begin
    int cand;
    pick_any = 1'b0;
    pick_idx = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      cand = rotate ? ((int'(last_idx) + 1 + k) % NCH) : k;
      if (req[cand]) begin
        pick_any = 1'b1;
        pick_idx = cand[IW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign pick_vec[g] = pick_any && (pick_idx == IW'(g));
  end
endmodule

// File: rtl/arb_grant_ctl.sv
module arb_grant_ctl #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] blk_done,
  input  logic [NCH-1:0] pick_vec,
  input  logic [IW-1:0]  pick_idx,
  input  logic           pick_any,
  output logic [NCH-1:0] grant_q,
  output logic [IW-1:0]  last_q,
  output logic           arb_pt
);
  assign arb_pt = (grant_q == '0) || (|(grant_q & blk_done));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= IW'(NCH - 1);
    end else if (arb_pt) begin
      grant_q <= pick_vec;
      if (pick_any) last_q <= pick_idx;
    end
  end
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [CSEL_W-1:0] cycle_sel,
  input  logic [NCH-1:0]    req,
  input  logic [NCH-1:0]    blk_done,
  output logic [NCH-1:0]    grant
);
  arb_policy_e    policy;
  logic [NCH-1:0] pick_vec;
  logic [IW-1:0]  pick_idx;
  logic           pick_any;
  logic [IW-1:0]  last_idx;
  logic           arb_pt;

  arb_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .policy (policy),
    .csel   (cycle_sel),
    .rdata  (cfg_rdata)
  );

  arb_pick #(.NCH(NCH)) u_pick (
    .req      (req),
    .rotate   (policy == POL_ROUND),
    .last_idx (last_idx),
    .pick_vec (pick_vec),
    .pick_idx (pick_idx),
    .pick_any (pick_any)
  );

  arb_grant_ctl #(.NCH(NCH)) u_gnt (
    .clk      (clk),
    .rst      (rst),
    .blk_done (blk_done),
    .pick_vec (pick_vec),
    .pick_idx (pick_idx),
    .pick_any (pick_any),
    .grant_q  (grant),
    .last_q   (last_idx),
    .arb_pt   (arb_pt)
  );
endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic [CSEL_W-1:0] cycle_sel,
  input logic [NCH-1:0]    req,
  input logic [NCH-1:0]    blk_done,
  input logic [NCH-1:0]    grant
);
  localparam logic [CFG_W-1:0] MASK =
    (CFG_W'(1) << POL_BIT) | (CFG_W'((1 << CSEL_W) - 1) << CSEL_LSB);

  logic at_point;
  assign at_point = (grant == '0) || (|(grant & blk_done));

  a_r4_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !at_point |=> grant == $past(grant));

  a_r8_no_req: assert property (@(posedge clk) disable iff (rst)
    (at_point && req == '0) |=> grant == '0);

  a_r5_to_requester: assert property (@(posedge clk) disable iff (rst)
    (at_point && req != '0) |=> (grant & $past(req)) != '0);

  a_r9_fixed_low: assert property (@(posedge clk) disable iff (rst)
    (at_point && req != '0 && !cfg_rdata[POL_BIT])
      |=> grant == ($past(req) & (~$past(req) + 1'b1)));

  a_r2_cfg_write: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & MASK));

  a_r3_csel_match: assert property (@(posedge clk) disable iff (rst)
    cycle_sel == cfg_rdata[CSEL_LSB +: CSEL_W]);
endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .cycle_sel (cycle_sel),
  .req       (req),
  .blk_done  (blk_done),
  .grant     (grant)
);

// File: tb/tb_dma_bus_arbiter.sv
`timescale 1ns/1ps
module tb_dma_bus_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  cycle_sel;
  logic [3:0]  req = '0;
  logic [3:0]  blk_done = '0;
  logic [3:0]  grant;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cycle_sel(cycle_sel), .req(req),
    .blk_done(blk_done), .grant(grant)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; blk_done = '0; cfg_we = 1'b0;
    step(); step();
    rst = 1'b0;
    step();
  endtask

  task automatic write_cfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  // End the current block: holder pulses done for one cycle.
  task automatic finish_block(input logic [3:0] next_req);
    req = next_req;
    blk_done = grant;
    step();
    blk_done = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    chk("R1 grant in reset", 32'(grant), 32'h0);
    chk("R1 rdata in reset", cfg_rdata, 32'h0);
    rst = 1'b0;
    step();
    chk("R1 grant after reset", 32'(grant), 32'h0);
    chk("R1 csel after reset", 32'(cycle_sel), 32'h0);
  endtask

  task automatic t_cfg();
    do_reset();
    write_cfg(32'hFFFF_FFFF);
    chk("R2 masked readback", cfg_rdata, 32'h800F_0000);
    chk("R3 cycle_sel F", 32'(cycle_sel), 32'hF);
    write_cfg(32'h0005_0000);
    chk("R2 second write", cfg_rdata, 32'h0005_0000);
    chk("R3 cycle_sel 5", 32'(cycle_sel), 32'h5);
  endtask

  task automatic t_fixed();
    do_reset();
    req = 4'b1100;
    step();
    chk("R9 fixed pick ch2", 32'(grant), 32'h4);
    finish_block(4'b1110);
    chk("R9 fixed pick ch1", 32'(grant), 32'h2);
    finish_block(4'b1000);
    chk("R9 fixed pick ch3", 32'(grant), 32'h8);
    finish_block(4'b0000);
    chk("R8 idle after done", 32'(grant), 32'h0);
  endtask

  task automatic t_hold();
    do_reset();
    req = 4'b1000;
    step();
    chk("R5 first grant", 32'(grant), 32'h8);
    req = 4'b1111;
    step();
    chk("R6 hold vs higher req", 32'(grant), 32'h8);
    blk_done = 4'b0111;
    step();
    chk("R7 foreign done ignored", 32'(grant), 32'h8);
    blk_done = '0;
    req = 4'b0000;
    step(); step();
    chk("R6 hold with req dropped", 32'(grant), 32'h8);
    finish_block(4'b0000);
    chk("R8 no req at point", 32'(grant), 32'h0);
    step();
    chk("R8 stays idle", 32'(grant), 32'h0);
  endtask

  task automatic t_rr();
    do_reset();
    write_cfg(32'h8000_0000);
    req = 4'b1111;
    step();
    chk("R10 rr first is ch0", 32'(grant), 32'h1);
    finish_block(4'b1111);
    chk("R10 rr ch1", 32'(grant), 32'h2);
    finish_block(4'b1111);
    chk("R10 rr ch2", 32'(grant), 32'h4);
    finish_block(4'b1111);
    chk("R10 rr ch3", 32'(grant), 32'h8);
    finish_block(4'b1111);
    chk("R10 rr wrap ch0", 32'(grant), 32'h1);
    finish_block(4'b0000);
    do_reset();
    write_cfg(32'h8000_0000);
    req = 4'b0100;
    step();
    chk("R10 rr lone ch2", 32'(grant), 32'h4);
    finish_block(4'b0011);
    chk("R10 rr skip wrap ch0", 32'(grant), 32'h1);
    finish_block(4'b0000);
  endtask

  task automatic t_switch();
    do_reset();
    req = 4'b1111;
    step();
    chk("R9 fixed start ch0", 32'(grant), 32'h1);
    write_cfg(32'h8000_0000);
    chk("R11 grant kept after write", 32'(grant), 32'h1);
    finish_block(4'b1111);
    chk("R11 rr used at next point", 32'(grant), 32'h2);
    write_cfg(32'h0000_0000);
    chk("R11 grant kept ch1", 32'(grant), 32'h2);
    finish_block(4'b1111);
    chk("R11 fixed used at next point", 32'(grant), 32'h1);
    finish_block(4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    step();
    t_reset();
    t_cfg();
    t_fixed();
    t_hold();
    t_rr();
    t_switch();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule